// File: doc/BRIEF.md
# Audio Master-Mode Clock Generator

This block turns a free-running master clock into the two clocks an audio serial port needs when it runs as clock master. It divides the master clock by whole numbers to make the bit clock and the frame (word-select) clock. A configuration write loads a 4-bit sampling-mode field and a bit-clock width select. The mode field sets how many master-clock cycles make one sample period: 256, 384, 512, 768 or 1024. The width select sets the bit clock to 32 or 64 periods per sample.

Every configuration write restarts both dividers from a known phase, so downstream serial logic always sees a clean first frame that begins with the frame clock low. A single-cycle frame-start strobe marks each falling edge of the frame clock. A mode code with no ratio assigned raises an error flag and holds every output low until a valid code is written.

Top module: `aclk_master_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bclk, fclk, frame_start and cfg_err are all 0. The reset configuration is 256 master cycles per sample with a 32-period bit clock.
- R2: The fclk period equals the selected ratio in master cycles. Mode bits [2:0] select the ratio: 000 gives 256, 001 gives 1024, 100 gives 384, 101 gives 768, 110 gives 512 and 111 gives 256. Bit 3 has no effect on the ratio.
- R3: With wide_bclk=0 the bclk period is ratio/32 master cycles. With wide_bclk=1 it is ratio/64 master cycles.
- R4: bclk stays high for exactly half its period and low for exactly half its period. This includes odd half-periods such as 3 cycles, which occur at 384 with wide_bclk=1.
- R5: fclk changes state only in the cycle where bclk falls. Each fclk level lasts 16 bclk periods when wide_bclk=0 and 32 bclk periods when wide_bclk=1.
- R6: Mode bits [2:0] of 010 or 011 are reserved, whatever bit 3 holds. A reserved code sets cfg_err to 1 and holds bclk, fclk and frame_start at 0. cfg_err returns to 0 after a write of a valid code.
- R7: The cycle after cfg_wr is sampled, bclk and fclk are both 0. bclk first rises ratio/64 (wide_bclk=0) or ratio/128 (wide_bclk=1) cycles after the write edge. fclk first rises ratio/2 cycles after the write edge.
- R8: frame_start is 1 for exactly one cycle, the same cycle in which fclk first reads 0 after reading 1. This holds except when the drop in fclk comes from a configuration write, which gives no pulse.
- R9: mode_code and wide_bclk are loaded only in a cycle where cfg_wr is 1. Changing them while cfg_wr is 0 does not change the clock timing or cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every output changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle configuration load strobe; also restarts the dividers |
| mode_code | input | 4 | Sampling-mode field; bits [2:0] pick the ratio |
| wide_bclk | input | 1 | Bit clock select: 0 for 32 periods per sample, 1 for 64 |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock at the sample rate, low for the first half of each frame |
| frame_start | output | 1 | One-cycle strobe at each frame clock falling edge |
| cfg_err | output | 1 | Reserved mode code is loaded |

## Verification
The properties assume that cfg_wr is a synchronous strobe that is low during reset and held for a single master cycle. They also assume that mode_code and wide_bclk are steady whenever cfg_wr is sampled. Under these assumptions, every change of fclk that does not follow a write lines up with a bclk fall.

The stimulus drives all inputs on the falling master edge, and raises cfg_wr for one cycle at a time. It changes the configuration inputs without a strobe only in the case that checks they are ignored. The runs cover every valid and reserved code, both bit-clock widths, both states of the ignored top mode bit, and restarts issued in the middle of a frame.

// File: rtl/aclk_pkg.sv
// Package: shared constants and the mode-to-ratio decode for the
// master-mode audio clock generator. Assumes the ratio fits RATIO_W bits.
package aclk_pkg;

    parameter int RATIO_W = 11;
    parameter int MODE_W  = 4;

    // Master cycles per sample for a mode code; 0 marks a reserved code.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] sel);
        case (sel)
            3'b000:  ratio_of = RATIO_W'(256);
            3'b001:  ratio_of = RATIO_W'(1024);
            3'b100:  ratio_of = RATIO_W'(384);
            3'b101:  ratio_of = RATIO_W'(768);
            3'b110:  ratio_of = RATIO_W'(512);
            3'b111:  ratio_of = RATIO_W'(256);
            default: ratio_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/aclk_cfg_reg.sv
// Configuration holder: loads the mode field and bit-clock width on a
// write strobe and derives the bit-clock half period and the run flag.
// Assumes cfg_wr is a one-cycle synchronous strobe.
module aclk_cfg_reg
    import aclk_pkg::*;
#(
    parameter int BFS_LO = 32,
    parameter int HW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              wide_in,
    output logic [HW-1:0]     half,
    output logic              wide,
    output logic              run
);

    localparam int LO_SHIFT = $clog2(2 * BFS_LO);
    localparam int HI_SHIFT = LO_SHIFT + 1;

    logic [2:0]         sel_q;
    logic               wide_q;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] shifted;
    logic               cfg_unused;

    // The top mode bit carries no meaning.
    assign cfg_unused = mode_in[MODE_W-1];

    // Load the configuration on a write; the reset default is code 111 with 32 periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 3'b111;
            wide_q <= 1'b0;
        end else if (cfg_wr) begin
            sel_q  <= mode_in[2:0];
            wide_q <= wide_in;
        end
    end

    // Derive the bit-clock half period in master cycles.
    always_comb begin
        ratio   = ratio_of(sel_q);
        shifted = wide_q ? (ratio >> HI_SHIFT) : (ratio >> LO_SHIFT);
        half    = shifted[HW-1:0];
        run     = (ratio != '0);
    end

    assign wide = wide_q;

endmodule

// File: rtl/aclk_bit_div.sv
// Bit-clock divider: toggles bclk every `half` master cycles, giving a
// 50% duty cycle for any whole half period, odd values included.
// Assumes half >= 2 whenever run is set.
module aclk_bit_div #(
    parameter int HW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          bclk,
    output logic          fall_tick
);

    logic [HW-1:0] hcnt;
    logic          at_end;

    // Flag the last cycle of the current half period.
    assign at_end    = (hcnt == half - HW'(1));
    assign fall_tick = run && bclk && at_end && !restart;

    // Count the half period and toggle the bit clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            hcnt <= '0;
            bclk <= 1'b0;
        end else if (at_end) begin
            hcnt <= '0;
            bclk <= ~bclk;
        end else begin
            hcnt <= hcnt + HW'(1);
        end
    end

endmodule

// File: rtl/aclk_frame_div.sv
// Frame-clock divider: counts bit-clock falling edges and toggles fclk
// after BFS_LO/2 or BFS_LO of them, with a strobe on each fclk fall.
// Assumes fall_tick is high for one cycle before each bclk fall.
module aclk_frame_div #(
    parameter int BFS_LO = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic wide,
    input  logic fall_tick,
    output logic fclk,
    output logic frame_start
);

    localparam int BW     = $clog2(BFS_LO);
    localparam int N_NARW = BFS_LO / 2;
    localparam int N_WIDE = BFS_LO;

    logic [BW-1:0] bcnt;
    logic [BW-1:0] last;

    // Last bit index of one frame-clock level.
    assign last = wide ? BW'(N_WIDE - 1) : BW'(N_NARW - 1);

    // Count bit periods per level, toggle fclk and strobe on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            bcnt        <= '0;
            fclk        <= 1'b0;
            frame_start <= 1'b0;
        end else if (fall_tick && bcnt == last) begin
            bcnt        <= '0;
            fclk        <= ~fclk;
            frame_start <= fclk;
        end else begin
            if (fall_tick) begin
                bcnt <= bcnt + BW'(1);
            end
            frame_start <= 1'b0;
        end
    end

endmodule

// File: rtl/aclk_master_gen.sv
// Top: master-mode audio clock generator. Combines the configuration
// holder with the bit and frame dividers. Assumes cfg_wr is a one-cycle
// strobe in the master clock domain.
module aclk_master_gen
    import aclk_pkg::*;
#(
    parameter int BFS_LO    = 32,
    parameter int MAX_RATIO = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              wide_bclk,
    output logic              bclk,
    output logic              fclk,
    output logic              frame_start,
    output logic              cfg_err
);

    localparam int HALF_MAX = MAX_RATIO / (2 * BFS_LO);
    localparam int HW       = $clog2(HALF_MAX + 1);

    logic [HW-1:0] half;
    logic          wide;
    logic          run;
    logic          fall_tick;

    aclk_cfg_reg #(.BFS_LO(BFS_LO), .HW(HW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .mode_in (mode_code),
        .wide_in (wide_bclk),
        .half    (half),
        .wide    (wide),
        .run     (run)
    );

    aclk_bit_div #(.HW(HW)) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cfg_wr),
        .run       (run),
        .half      (half),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    aclk_frame_div #(.BFS_LO(BFS_LO)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (cfg_wr),
        .run         (run),
        .wide        (wide),
        .fall_tick   (fall_tick),
        .fclk        (fclk),
        .frame_start (frame_start)
    );

    // Error flag follows the loaded code; it is low in reset because the default is valid.
    assign cfg_err = !run;

endmodule

// File: rtl/aclk_master_gen_chk.sv
// Checker: port-level timing properties of the master clock generator.
module aclk_master_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic bclk,
    input logic fclk,
    input logic frame_start,
    input logic cfg_err
);

    // R6
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bclk && !fclk && !frame_start));

    // R7
    restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!bclk && !fclk));

    // R5
    fclk_on_bfall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fclk != $past(fclk)) && !$past(cfg_wr)) |-> ($past(bclk) && !bclk));

    // R8
    fs_on_ffall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ($past(fclk) && !fclk && !$past(cfg_wr)));

    // R8
    ffall_has_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fclk) && !fclk && !$past(cfg_wr)) |-> frame_start);

    // R8
    fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

endmodule

bind aclk_master_gen aclk_master_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .bclk        (bclk),
    .fclk        (fclk),
    .frame_start (frame_start),
    .cfg_err     (cfg_err)
);

// File: tb/sim_aclk_master_gen.sv
`timescale 1ns/1ps
module sim_aclk_master_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] mode_code = 4'b0111;
    logic       wide_bclk = 1'b0;
    logic       bclk, fclk, frame_start, cfg_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int cyc0 = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Free-running cycle count, stable when sampled on the falling edge.
    always @(posedge clk) cyc <= cyc + 1;

    aclk_master_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .mode_code(mode_code),
        .wide_bclk(wide_bclk), .bclk(bclk), .fclk(fclk),
        .frame_start(frame_start), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a configuration; t=0 is the falling edge right after the write edge.
    task automatic cfg_write(input logic [3:0] code, input logic wide);
        @(negedge clk);
        mode_code = code;
        wide_bclk = wide;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cyc0 = cyc;
    endtask

    // Wait until bclk (which=0) or fclk (which=1) reads val; return cycles since t=0.
    task automatic wait_sig(input int which, input bit val, output int t);
        int n = 0;
        while (((which == 0) ? bclk : fclk) != val && n < 6000) begin
            @(negedge clk);
            n++;
        end
        t = cyc - cyc0;
    endtask

    // Measure the first bit and frame timing after a restart.
    task automatic measure(input int ratio, input bit wide, input string tag);
        int h = ratio / (wide ? 128 : 64);
        int t1, t2, t3, tf1, tf2, tf3;
        wait_sig(0, 1'b1, t1);
        chk(t1 == h, {"R7 first bclk rise ", tag}, t1, h);
        wait_sig(0, 1'b0, t2);
        chk(t2 - t1 == h, {"R4 bclk high ", tag}, t2 - t1, h);
        wait_sig(0, 1'b1, t3);
        chk(t3 - t2 == h, {"R4 bclk low ", tag}, t3 - t2, h);
        chk(t3 - t1 == ratio / (wide ? 64 : 32), {"R3 bclk period ", tag}, t3 - t1, ratio / (wide ? 64 : 32));
        wait_sig(1, 1'b1, tf1);
        chk(tf1 == ratio / 2, {"R5 first fclk rise ", tag}, tf1, ratio / 2);
        chk(bclk == 1'b0, {"R5 fclk rise on bclk fall ", tag}, bclk, 0);
        wait_sig(1, 1'b0, tf2);
        chk(tf2 == ratio, {"R2 fclk fall ", tag}, tf2, ratio);
        chk(frame_start == 1'b1, {"R8 strobe at fclk fall ", tag}, frame_start, 1);
        @(negedge clk);
        chk(frame_start == 1'b0, {"R8 strobe one cycle ", tag}, frame_start, 0);
        wait_sig(1, 1'b1, tf3);
        chk(tf3 - tf1 == ratio, {"R2 fclk period ", tag}, tf3 - tf1, ratio);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(!bclk && !fclk && !frame_start && !cfg_err, "R1 outputs low in reset",
            {bclk, fclk, frame_start, cfg_err}, 0);
        rst_n = 1'b1;
        cyc0 = cyc;
        @(negedge clk);
        chk(!bclk && !fclk && !cfg_err, "R1 outputs low after reset", {bclk, fclk, cfg_err}, 0);
        measure(256, 1'b0, "R1 default");
    endtask

    task automatic test_mode(input logic [3:0] code, input bit wide, input int ratio, input string tag);
        cfg_write(code, wide);
        chk(!bclk && !fclk, {"R7 low after write ", tag}, {bclk, fclk}, 0);
        chk(!cfg_err, {"R2 valid code ", tag}, cfg_err, 0);
        measure(ratio, wide, tag);
    endtask

    task automatic test_reserved(input logic [3:0] code, input string tag);
        int hits = 0;
        cfg_write(code, 1'b0);
        chk(cfg_err == 1'b1, {"R6 error flag ", tag}, cfg_err, 1);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (bclk || fclk || frame_start) hits++;
        end
        chk(hits == 0, {"R6 outputs held low ", tag}, hits, 0);
    endtask

    task automatic test_ignore_unwritten();
        cfg_write(4'b0000, 1'b0);
        @(negedge clk);
        mode_code = 4'b0010;
        wide_bclk = 1'b1;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R9 unwritten reserved code ignored", cfg_err, 0);
        measure(256, 1'b0, "R9 unwritten change");
    endtask

    task automatic test_midframe_restart();
        int t;
        cfg_write(4'b0110, 1'b0);
        wait_sig(1, 1'b1, t);
        repeat (7) @(negedge clk);
        cfg_write(4'b0110, 1'b0);
        chk(!fclk && !bclk, "R7 restart mid-frame forces low", {bclk, fclk}, 0);
        chk(!frame_start, "R8 no strobe on restart", frame_start, 0);
        measure(512, 1'b0, "R7 after mid-frame restart");
    endtask

    initial begin
        test_reset();
        test_mode(4'b0000, 1'b0, 256, "code0000 n");
        test_mode(4'b0111, 1'b1, 256, "code0111 w");
        test_mode(4'b0001, 1'b1, 1024, "code0001 w");
        test_mode(4'b1100, 1'b0, 384, "R2 top bit code1100 n");
        test_mode(4'b0100, 1'b1, 384, "R4 odd half code0100 w");
        test_mode(4'b0101, 1'b0, 768, "code0101 n");
        test_mode(4'b1110, 1'b1, 512, "code1110 w");
        test_reserved(4'b0010, "code0010");
        test_reserved(4'b1011, "code1011");
        test_mode(4'b0111, 1'b0, 256, "R6 recovery");
        test_ignore_unwritten();
        test_midframe_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule